// File: doc/BRIEF.md
# PWM Duty Speed Command Processor

This block turns an external pulse-width speed input into a smoothed 9-bit amplitude command for a three-phase motor drive. Each input period is measured with cycle counters. The high time is divided by the period to give a duty code from 0 to 511, so one step is 1/512, about 0.2%. The codes pass through a first-order lag whose time constant is `TICK_CYC * 2^SHIFT` clock cycles. The defaults give 16 M cycles, which is 80 ms at 200 MHz. The filtered value is then raised to a selectable floor, or turned into a standby request when it is very small.

A separate idle detector watches the pin itself. If the pin stays low long enough and sleep is enabled by parameter, the block enters sleep. The first high level on the pin afterwards wakes it. A wake acts like a fresh start: the filter and the period measurement are cleared, and the command rises again from zero.

Top module: `spd_cmd_proc`

## Requirements
- R1: With a periodic input of period T cycles (T < `PERIOD_TMO`) and high time H cycles, the settled command equals floor(512*H/T). It saturates at 511 when H >= T.
- R2: The command follows steps in the duty through a first-order lag. After a step up from zero, the first non-standby value is below one quarter of the new target. The command then rises without decreasing and settles exactly on the target.
- R3: `min_sel` chooses the floor. Code 0 sets no floor, code 1 sets 26 (5%), code 2 sets 51 (10%) and code 3 sets 67 (13%). When the block is not in standby and the filtered duty is below the floor, `cmd_o` equals the floor.
- R4: A filtered duty below 8 (1.5% of 512) sets `standby_o` to 1 and `cmd_o` to 0. A value of 8 or more clears standby.
- R5: If no rising edge arrives within `PERIOD_TMO` cycles, the duty is taken from the pin level: 511 when the pin is high and 0 when it is low.
- R6: With `SLEEP_EN`=1, `sleep_o` rises after the pin has been low for `SLEEP_CYC` consecutive cycles, and not before. While `sleep_o` is 1, `standby_o` is also 1.
- R7: With `SLEEP_EN`=0, `sleep_o` stays at 0 however long the pin is low.
- R8: A high pin during sleep clears `sleep_o` on the next cycle, with `standby_o`=1 and `cmd_o`=0. The filter restarts from zero and the first rising edge afterwards only rearms the period measurement.
- R9: Synchronous reset gives `cmd_o`=0, `standby_o`=1 and `sleep_o`=0, with the filter cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Speed input, already synchronized to clk |
| min_sel | input | 2 | Floor select: 0 none, 1 = 26, 2 = 51, 3 = 67 |
| cmd_o | output | 9 | Filtered and clamped amplitude command |
| standby_o | output | 1 | Drive must be held in high impedance |
| sleep_o | output | 1 | Idle sleep entered; wake on next high input |

## Verification
A fault in the measurement counters or in the divider shows up as a settled command that misses floor(512*H/T). This appears within a few filter time constants of a new pattern. A corrupt filter accumulator shows up at once as a command that overshoots, decreases during a rising step, or never lands exactly on its target. Mode faults are seen within one cycle at the flags. They show up as a command that is not zero during standby, a command below the floor while running, sleep entered while the pin was high, or a sleep flag that survives a high input.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int DUTY_W = 9;
  localparam logic [DUTY_W-1:0] DUTY_FULL = 9'd511;
  localparam logic [DUTY_W-1:0] STBY_CODE = 9'd8;

  typedef enum logic [1:0] {MODE_STBY, MODE_RUN, MODE_SLEEP} mode_e;

  function automatic logic [DUTY_W-1:0] floor_code(input logic [1:0] sel);
    case (sel)
      2'd0:    return 9'd0;
      2'd1:    return 9'd26;
      2'd2:    return 9'd51;
      default: return 9'd67;
    endcase
  endfunction
endpackage

// File: rtl/spd_duty_meas.sv
module spd_duty_meas #(
  parameter int PERIOD_TMO = 16384,
  localparam int CNT_W = $clog2(PERIOD_TMO + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr,
  input  logic                          pin,
  output logic                          div_start,
  output logic [CNT_W-1:0]              div_num,
  output logic [CNT_W-1:0]              div_den,
  output logic                          lvl_vld,
  output logic [spd_pkg::DUTY_W-1:0]    lvl_duty
);
  import spd_pkg::*;

  logic             pin_q;
  logic             armed;
  logic [CNT_W-1:0] per_cnt;
  logic [CNT_W-1:0] hi_cnt;
  logic             rise;

  assign rise = pin & ~pin_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pin_q     <= clr ? pin : 1'b0;
      armed     <= 1'b0;
      per_cnt   <= CNT_W'(1);
      hi_cnt    <= '0;
      div_start <= 1'b0;
      div_num   <= '0;
      div_den   <= CNT_W'(1);
      lvl_vld   <= 1'b0;
      lvl_duty  <= '0;
    end else begin
      pin_q     <= pin;
      div_start <= 1'b0;
      lvl_vld   <= 1'b0;
      if (rise) begin
        if (armed) begin
          div_start <= 1'b1;
          div_num   <= hi_cnt;
          div_den   <= per_cnt;
        end
        armed   <= 1'b1;
        per_cnt <= CNT_W'(1);
        hi_cnt  <= CNT_W'(1);
      end else if (per_cnt == CNT_W'(PERIOD_TMO)) begin
        lvl_vld  <= 1'b1;
        lvl_duty <= pin ? DUTY_FULL : '0;
        armed    <= 1'b0;
        per_cnt  <= CNT_W'(1);
        hi_cnt   <= pin ? CNT_W'(1) : '0;
      end else begin
        per_cnt <= per_cnt + CNT_W'(1);
        hi_cnt  <= hi_cnt + CNT_W'(pin);
      end
    end
  end
endmodule

// File: rtl/spd_ratio_div.sv
module spd_ratio_div #(
  parameter int NW = 15,
  parameter int QW = 9,
  localparam int LW = $clog2(QW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [NW-1:0] den,
  output logic          done,
  output logic [QW-1:0] quo
);
  logic [NW:0]   rem;
  logic [NW-1:0] den_q;
  logic [QW-1:0] q;
  logic [LW-1:0] left;
  logic          busy;
  logic [NW:0]   rem_sh;
  logic          take;

  assign rem_sh = {rem[NW-1:0], 1'b0};
  assign take   = rem_sh >= {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rem   <= '0;
      den_q <= '0;
      q     <= '0;
      left  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      quo   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        if (num >= den) begin
          done <= 1'b1;
          quo  <= '1;
          busy <= 1'b0;
        end else begin
          rem   <= {1'b0, num};
          den_q <= den;
          q     <= '0;
          left  <= LW'(QW);
          busy  <= 1'b1;
        end
      end else if (busy) begin
        rem  <= take ? (rem_sh - {1'b0, den_q}) : rem_sh;
        q    <= {q[QW-2:0], take};
        left <= left - LW'(1);
        if (left == LW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          quo  <= {q[QW-2:0], take};
        end
      end
    end
  end
endmodule

// File: rtl/spd_lag_filter.sv
module spd_lag_filter #(
  parameter int TICK_CYC = 250000,
  parameter int SHIFT    = 6,
  localparam int FRAC = SHIFT + 1,
  localparam int AW   = spd_pkg::DUTY_W + FRAC,
  localparam int TW   = $clog2(TICK_CYC)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       x_vld,
  input  logic [spd_pkg::DUTY_W-1:0] x,
  output logic [spd_pkg::DUTY_W-1:0] y
);
  import spd_pkg::*;

  logic [DUTY_W-1:0]  x_q;
  logic [AW-1:0]      acc;
  logic [TW-1:0]      tcnt;
  logic               tick;
  logic signed [AW+1:0] diff;
  logic signed [AW+1:0] step;
  logic [AW:0]        rnd;

  assign tick = tcnt == TW'(TICK_CYC - 1);
  assign diff = $signed({2'b00, x_q, {FRAC{1'b0}}}) - $signed({2'b00, acc});
  assign step = diff >>> SHIFT;
  assign rnd  = {1'b0, acc} + (AW+1)'(1 << (FRAC - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      x_q  <= '0;
      acc  <= '0;
      tcnt <= '0;
      y    <= '0;
    end else begin
      if (x_vld) x_q <= x;
      tcnt <= tick ? '0 : tcnt + TW'(1);
      if (tick) acc <= acc + step[AW-1:0];
      y <= rnd[AW] ? DUTY_FULL : rnd[AW-1:FRAC];
    end
  end
endmodule

// File: rtl/spd_mode_ctl.sv
module spd_mode_ctl #(
  parameter int SLEEP_CYC = 100000,
  parameter bit SLEEP_EN  = 1'b1,
  localparam int LW = $clog2(SLEEP_CYC + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pin,
  input  logic [1:0]                 min_sel,
  input  logic [spd_pkg::DUTY_W-1:0] filt,
  output logic                       wake,
  output logic [spd_pkg::DUTY_W-1:0] cmd_o,
  output logic                       standby_o,
  output logic                       sleep_o
);
  import spd_pkg::*;

  mode_e             mode_q;
  mode_e             mode_d;
  logic              sleep_req;
  logic [DUTY_W-1:0] flo;

  generate
    if (SLEEP_EN) begin : g_idle
      logic [LW-1:0] low_cnt;
      always_ff @(posedge clk) begin
        if (rst || pin) low_cnt <= '0;
        else if (low_cnt != LW'(SLEEP_CYC)) low_cnt <= low_cnt + LW'(1);
      end
      assign sleep_req = !pin && (low_cnt >= LW'(SLEEP_CYC - 1));
    end else begin : g_no_idle
      assign sleep_req = 1'b0;
    end
  endgenerate

  assign wake = (mode_q == MODE_SLEEP) && pin;
  assign flo  = floor_code(min_sel);

  always_comb begin
    if (mode_q == MODE_SLEEP)   mode_d = pin ? MODE_STBY : MODE_SLEEP;
    else if (sleep_req)         mode_d = MODE_SLEEP;
    else if (filt < STBY_CODE)  mode_d = MODE_STBY;
    else                        mode_d = MODE_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_STBY;
      cmd_o     <= '0;
      standby_o <= 1'b1;
      sleep_o   <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      standby_o <= mode_d != MODE_RUN;
      sleep_o   <= mode_d == MODE_SLEEP;
      if (mode_d == MODE_RUN) cmd_o <= (filt < flo) ? flo : filt;
      else                    cmd_o <= '0;
    end
  end
endmodule

// File: rtl/spd_cmd_proc.sv
module spd_cmd_proc #(
  parameter int PERIOD_TMO = 16384,
  parameter int SLEEP_CYC  = 100000,
  parameter int TICK_CYC   = 250000,
  parameter int SHIFT      = 6,
  parameter bit SLEEP_EN   = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwm_in,
  input  logic [1:0] min_sel,
  output logic [8:0] cmd_o,
  output logic       standby_o,
  output logic       sleep_o
);
  import spd_pkg::*;
  localparam int CNT_W = $clog2(PERIOD_TMO + 1);

  logic              wake;
  logic              div_start;
  logic [CNT_W-1:0]  div_num;
  logic [CNT_W-1:0]  div_den;
  logic              lvl_vld;
  logic [DUTY_W-1:0] lvl_duty;
  logic              div_done;
  logic [DUTY_W-1:0] div_quo;
  logic              x_vld;
  logic [DUTY_W-1:0] x_val;
  logic [DUTY_W-1:0] filt;

  spd_duty_meas #(.PERIOD_TMO(PERIOD_TMO)) u_meas (
    .clk(clk), .rst(rst), .clr(wake), .pin(pwm_in),
    .div_start(div_start), .div_num(div_num), .div_den(div_den),
    .lvl_vld(lvl_vld), .lvl_duty(lvl_duty)
  );

  spd_ratio_div #(.NW(CNT_W), .QW(DUTY_W)) u_div (
    .clk(clk), .rst(rst), .clr(wake), .start(div_start),
    .num(div_num), .den(div_den), .done(div_done), .quo(div_quo)
  );

  assign x_vld = div_done | lvl_vld;
  assign x_val = div_done ? div_quo : lvl_duty;

  spd_lag_filter #(.TICK_CYC(TICK_CYC), .SHIFT(SHIFT)) u_filt (
    .clk(clk), .rst(rst), .clr(wake), .x_vld(x_vld), .x(x_val), .y(filt)
  );

  spd_mode_ctl #(.SLEEP_CYC(SLEEP_CYC), .SLEEP_EN(SLEEP_EN)) u_mode (
    .clk(clk), .rst(rst), .pin(pwm_in), .min_sel(min_sel), .filt(filt),
    .wake(wake), .cmd_o(cmd_o), .standby_o(standby_o), .sleep_o(sleep_o)
  );
endmodule

// File: rtl/spd_cmd_proc_chk.sv
module spd_cmd_proc_chk #(
  parameter bit SLEEP_EN = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       pwm_in,
  input logic [1:0] min_sel,
  input logic [8:0] cmd_o,
  input logic       standby_o,
  input logic       sleep_o
);
  import spd_pkg::*;

  p_reset_state_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cmd_o == 9'd0 && standby_o && !sleep_o));

  p_floor_held_r3: assert property (@(posedge clk) disable iff (rst)
    !standby_o |-> cmd_o >= floor_code($past(min_sel)));

  p_run_above_cut_r4: assert property (@(posedge clk) disable iff (rst)
    !standby_o |-> cmd_o >= STBY_CODE);

  p_stby_zero_r4: assert property (@(posedge clk) disable iff (rst)
    standby_o |-> cmd_o == 9'd0);

  p_sleep_implies_stby_r6: assert property (@(posedge clk) disable iff (rst)
    sleep_o |-> standby_o);

  p_sleep_from_low_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_o) |-> !$past(pwm_in));

  p_sleep_off_r7: assert property (@(posedge clk) disable iff (rst)
    !SLEEP_EN |-> !sleep_o);

  p_wake_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (sleep_o && pwm_in) |=> (!sleep_o && standby_o && cmd_o == 9'd0));
endmodule

bind spd_cmd_proc spd_cmd_proc_chk #(.SLEEP_EN(SLEEP_EN)) u_chk (
  .clk(clk), .rst(rst), .pwm_in(pwm_in), .min_sel(min_sel),
  .cmd_o(cmd_o), .standby_o(standby_o), .sleep_o(sleep_o)
);

// File: tb/spd_cmd_proc_bench.sv
`timescale 1ns/1ps
module spd_cmd_proc_bench;
  localparam int TMO   = 256;
  localparam int SLP   = 1000;
  localparam int TICK  = 4;
  localparam int SHF   = 3;
  localparam int SETTLE = 1000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [8:0] cmd, cmd_ns;
  logic       stby, stby_ns, slp, slp_ns;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  int gmode = 2;
  int per = 128;
  int hi = 64;
  int phase = 0;

  always #2.5 clk = ~clk;

  spd_cmd_proc #(.PERIOD_TMO(TMO), .SLEEP_CYC(SLP), .TICK_CYC(TICK),
                 .SHIFT(SHF), .SLEEP_EN(1'b1)) u_spd_cmd_proc (
    .clk(clk), .rst(rst), .pwm_in(pin), .min_sel(sel),
    .cmd_o(cmd), .standby_o(stby), .sleep_o(slp));

  spd_cmd_proc #(.PERIOD_TMO(TMO), .SLEEP_CYC(SLP), .TICK_CYC(TICK),
                 .SHIFT(SHF), .SLEEP_EN(1'b0)) u_spd_cmd_proc_nosleep (
    .clk(clk), .rst(rst), .pwm_in(pin), .min_sel(sel),
    .cmd_o(cmd_ns), .standby_o(stby_ns), .sleep_o(slp_ns));

  initial begin
    forever begin
      @(negedge clk);
      if (gmode == 0) begin
        pin = phase < hi;
        phase = (phase + 1 >= per) ? 0 : phase + 1;
      end else begin
        pin = gmode == 1;
      end
    end
  end

  function automatic int exp_duty(int t, int h);
    int d = (h * 512) / t;
    return d > 511 ? 511 : d;
  endfunction

  function automatic int floor_of(int s);
    case (s)
      0: return 0;
      1: return 26;
      2: return 51;
      default: return 67;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_pwm(int t, int h);
    per = t; hi = h; phase = 0; gmode = 0;
  endtask

  // Settled check against expected duty d under floor select s
  task automatic chk_settled(int d, int s, string req);
    int e;
    wait_cyc(SETTLE);
    if (d < 8) begin
      check(stby == 1'b1, req, stby, 1);
      check(cmd == 9'd0, req, cmd, 0);
    end else begin
      e = (d < floor_of(s)) ? floor_of(s) : d;
      check(stby == 1'b0, req, stby, 0);
      check(cmd == 9'(e), req, cmd, e);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int first_run, prev, mono_ok, t, h, s;
    void'($urandom(32'd1729));
    wait_cyc(10);
    // R9: reset state
    check(cmd == 9'd0, "R9", cmd, 0);
    check(stby == 1'b1, "R9", stby, 1);
    check(slp == 1'b0, "R9", slp, 0);
    rst = 1'b0;

    // R2: step response from zero to 256
    set_pwm(128, 64);
    first_run = -1; prev = 0; mono_ok = 1;
    for (int i = 0; i < SETTLE; i++) begin
      @(negedge clk);
      if (!stby && first_run < 0) first_run = cmd;
      if (int'(cmd) < prev) mono_ok = 0;
      prev = cmd;
    end
    check(first_run >= 8 && first_run < 64, "R2", first_run, 63);
    check(mono_ok == 1, "R2", mono_ok, 1);
    check(cmd == 9'd256, "R2", cmd, 256);

    // R1: directed duties
    set_pwm(128, 127); chk_settled(508, 0, "R1");
    set_pwm(200, 50);  chk_settled(exp_duty(200, 50), 0, "R1");

    // R4: standby boundary
    set_pwm(128, 2); chk_settled(8, 0, "R4");
    set_pwm(128, 1); chk_settled(4, 0, "R4");

    // R3: floor values at duty 16
    for (int k = 0; k < 4; k++) begin
      sel = 2'(k);
      set_pwm(128, 4); chk_settled(16, k, "R3");
    end

    // R5: static pin levels
    sel = 2'd3;
    gmode = 1; chk_settled(511, 3, "R5");
    gmode = 2; wait_cyc(700);
    check(stby == 1'b1 && cmd == 9'd0, "R5", cmd, 0);
    check(slp == 1'b0, "R6", slp, 0);

    // R1/R3/R4: random patterns
    for (int k = 0; k < 40; k++) begin
      t = 64 + int'($urandom_range(0, 186));
      h = 1 + int'($urandom_range(0, t - 2));
      s = int'($urandom_range(0, 3));
      sel = 2'(s);
      set_pwm(t, h);
      chk_settled(exp_duty(t, h), s, "R1");
    end

    // R6/R7: sleep entry timing
    sel = 2'd0;
    gmode = 1; wait_cyc(20);
    gmode = 2; wait_cyc(SLP - 50);
    check(slp == 1'b0, "R6", slp, 0);
    wait_cyc(100);
    check(slp == 1'b1, "R6", slp, 1);
    check(stby == 1'b1, "R6", stby, 1);
    check(slp_ns == 1'b0, "R7", slp_ns, 0);
    check(stby_ns == 1'b1, "R7", stby_ns, 1);

    // R8: wake and restart
    set_pwm(128, 64);
    wait_cyc(2);
    check(slp == 1'b0, "R8", slp, 0);
    check(stby == 1'b1 && cmd == 9'd0, "R8", cmd, 0);
    wait_cyc(100);
    check(stby == 1'b1, "R8", stby, 1);
    chk_settled(256, 0, "R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule